// File: doc/BRIEF.md
# USB Control Endpoint Status and Handshake Controller

This block holds the status flags and makes the handshake decision for the control endpoint of a USB device. Firmware reaches it through per-bit set and clear strobes. The packet engine reports each transaction to the block: a received SETUP, a received OUT data packet with its toggle bit, an IN token, or the host's ACK to data the block sent. For every transaction the block returns ACK, NAK, STALL, "send data" or nothing.

The endpoint runs full-duplex, so both directions are live on the same flag set. It keeps a separate DATA0/DATA1 toggle for each direction. It decides when the endpoint FIFO may be reused and drives a maskable interrupt. The firmware-held direction bit tells the block whether the current stage is an IN data stage or an OUT/status stage. A SETUP arrival always wins: it is acknowledged, it wipes the other flags, and it restarts both toggle sequences.

All outputs are registered. A transaction offered before clock edge n is answered by the outputs that follow edge n.

Top module: `usb_ctl_ep_status`

## Requirements
- R1: A SETUP report (`pkt_kind_i`=0) is always answered ACK (`hs_o`=1), even while a stall or other flags are pending, and it sets the setup-received flag (`status_o[4]`).
- R2: In the cycle the setup-received flag sets, every other status bit is cleared: direction [0], transmit-ready [1], transmit-done [2], OUT-received [3] and stall [5]. This holds even if firmware sets a bit in that same cycle.
- R3: `irq_o` is high after an edge exactly when `irq_en_i` was high at that edge and at least one of transmit-done, OUT-received or setup-received is set.
- R4: `fifo_free_o` is low while any of transmit-ready, OUT-received or setup-received is set, and high otherwise. Clearing setup-received frees the FIFO.
- R5: An IN token (`pkt_kind_i`=2) with transmit-ready clear gets NAK (2). With transmit-ready set it gets DATA (4), and `tx_zlp_o` shows whether `fifo_cnt_i` was zero.
- R6: The host's ACK (`pkt_kind_i`=3) after a DATA response clears transmit-ready, sets transmit-done and flips the IN toggle. A host ACK with no data outstanding changes nothing and gets no response (0).
- R7: An OUT packet (`pkt_kind_i`=1) whose toggle matches the expected OUT toggle gets ACK, sets OUT-received and flips the expected toggle. While OUT-received or setup-received is set, any OUT gets NAK.
- R8: An OUT packet with the wrong toggle gets ACK but is discarded: no flag is set and the expected toggle is unchanged.
- R9: A SETUP sets the IN toggle to DATA1 and the expected OUT toggle to DATA1.
- R10: With direction=1 (IN data stage), DATA responses carry the IN toggle on `tx_pid1_o`. With direction=0 (status stage), an IN response is always sent as DATA1.
- R11: With the stall bit set, IN and OUT tokens get STALL (3). The next SETUP clears the stall bit.
- R12: Firmware can set and clear direction, transmit-ready and stall. It can only clear transmit-done, OUT-received and setup-received; a firmware set on those bits is ignored. When set and clear of the same bit are strobed together, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_set_i | input | 6 | Firmware set strobes, one per status bit |
| cpu_clr_i | input | 6 | Firmware clear strobes, one per status bit |
| irq_en_i | input | 1 | Endpoint interrupt enable |
| pkt_valid_i | input | 1 | Transaction report strobe from the packet engine |
| pkt_kind_i | input | 2 | 0 SETUP, 1 OUT, 2 IN token, 3 host ACK |
| pkt_pid1_i | input | 1 | Toggle of the received OUT data packet (1 = DATA1) |
| fifo_cnt_i | input | CNT_W | Bytes currently held in the endpoint FIFO |
| status_o | output | 6 | Status flags: [0] dir, [1] tx ready, [2] tx done, [3] OUT received, [4] setup received, [5] stall |
| hs_o | output | 3 | Response: 0 none, 1 ACK, 2 NAK, 3 STALL, 4 DATA |
| tx_pid1_o | output | 1 | Toggle to send with the last DATA response |
| tx_zlp_o | output | 1 | Last DATA response is zero length |
| irq_o | output | 1 | Endpoint interrupt |
| fifo_free_o | output | 1 | FIFO available for the next transaction |

## Verification
The hardest state to reach is an IN toggle of DATA0 while the direction bit is already back at 0. Only in that state does the forced-DATA1 status response differ from plain toggle tracking. The stimulus gets there by completing one IN data packet under direction=1, which flips the toggle, then clearing direction and arming a zero-length status IN. The mismatched-toggle OUT likewise needs one accepted OUT first, so that the expected toggle has moved off DATA1. A second SETUP is offered while stall, direction and transmit-ready are all set, together with a simultaneous firmware set, to show that the wipe overrides everything.

// File: rtl/usb_ctl_ep_pkg.sv
package usb_ctl_ep_pkg;

  typedef enum logic [1:0] {
    PK_SETUP = 2'd0,
    PK_OUT   = 2'd1,
    PK_IN    = 2'd2,
    PK_HACK  = 2'd3
  } pkt_kind_e;

  typedef enum logic [2:0] {
    HS_NONE  = 3'd0,
    HS_ACK   = 3'd1,
    HS_NAK   = 3'd2,
    HS_STALL = 3'd3,
    HS_DATA  = 3'd4
  } hs_e;

  localparam int FLAG_W    = 6;
  localparam int F_DIR     = 0;
  localparam int F_TXRDY   = 1;
  localparam int F_TXDONE  = 2;
  localparam int F_RXOUT   = 3;
  localparam int F_RXSETUP = 4;
  localparam int F_STALL   = 5;

  // bits firmware may set; the others are hardware-set, firmware-cleared
  localparam logic [FLAG_W-1:0] CPU_SET_MASK = 6'b100011;
  // bits that raise the interrupt
  localparam logic [FLAG_W-1:0] IRQ_MASK     = 6'b011100;
  // bits that keep the FIFO owned
  localparam logic [FLAG_W-1:0] HOLD_MASK    = 6'b011010;

endpackage

// File: rtl/usb_ep_flags.sv
module usb_ep_flags
  import usb_ctl_ep_pkg::*;
#(
  parameter int              W         = FLAG_W,
  parameter logic [W-1:0]    SET_MASK  = CPU_SET_MASK,
  parameter int              WIPE_KEEP = F_RXSETUP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cpu_set,
  input  logic [W-1:0] cpu_clr,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  input  logic         wipe,
  output logic [W-1:0] flags_q,
  output logic [W-1:0] flags_nxt
);

  // priority per bit: wipe, hardware set, hardware clear, firmware set, firmware clear
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic KEEP = (i == WIPE_KEEP);
    assign flags_nxt[i] = wipe                      ? KEEP :
                          hw_set[i]                 ? 1'b1 :
                          hw_clr[i]                 ? 1'b0 :
                          (SET_MASK[i] & cpu_set[i]) ? 1'b1 :
                          cpu_clr[i]                ? 1'b0 :
                                                      flags_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_nxt;
  end

endmodule

// File: rtl/usb_ep_toggle.sv
module usb_ep_toggle #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [N-1:0] flip,
  output logic [N-1:0] tog_q
);

  always_ff @(posedge clk) begin
    if (rst)          tog_q <= '0;
    else if (restart) tog_q <= '1;
    else              tog_q <= tog_q ^ flip;
  end

endmodule

// File: rtl/usb_ep_resp.sv
module usb_ep_resp
  import usb_ctl_ep_pkg::*;
(
  input  logic              valid,
  input  logic [1:0]        kind,
  input  logic              pid1,
  input  logic [FLAG_W-1:0] flags,
  input  logic              tog_in,
  input  logic              tog_out,
  input  logic              in_flight,
  output hs_e               hs,
  output logic              setup_evt,
  output logic              out_accept,
  output logic              in_send,
  output logic              in_done,
  output logic              pid_sel
);

  logic stalled, out_busy;
  assign stalled  = flags[F_STALL];
  assign out_busy = flags[F_RXOUT] | flags[F_RXSETUP];
  // status stage (dir=0) always answers with DATA1
  assign pid_sel  = flags[F_DIR] ? tog_in : 1'b1;

  always_comb begin
    hs         = HS_NONE;
    setup_evt  = 1'b0;
    out_accept = 1'b0;
    in_send    = 1'b0;
    in_done    = 1'b0;
    if (valid) begin
      case (pkt_kind_e'(kind))
        PK_SETUP: begin
          hs        = HS_ACK;
          setup_evt = 1'b1;
        end
        PK_OUT: begin
          if (stalled)       hs = HS_STALL;
          else if (out_busy) hs = HS_NAK;
          else begin
            hs         = HS_ACK;
            out_accept = (pid1 == tog_out);
          end
        end
        PK_IN: begin
          if (stalled)             hs = HS_STALL;
          else if (!flags[F_TXRDY]) hs = HS_NAK;
          else begin
            hs      = HS_DATA;
            in_send = 1'b1;
          end
        end
        default: in_done = in_flight;
      endcase
    end
  end

endmodule

// File: rtl/usb_ctl_ep_status.sv
module usb_ctl_ep_status
  import usb_ctl_ep_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [5:0]        cpu_set_i,
  input  logic [5:0]        cpu_clr_i,
  input  logic              irq_en_i,
  input  logic              pkt_valid_i,
  input  logic [1:0]        pkt_kind_i,
  input  logic              pkt_pid1_i,
  input  logic [CNT_W-1:0]  fifo_cnt_i,
  output logic [5:0]        status_o,
  output logic [2:0]        hs_o,
  output logic              tx_pid1_o,
  output logic              tx_zlp_o,
  output logic              irq_o,
  output logic              fifo_free_o
);

  localparam int NDIR  = 2;
  localparam int T_IN  = 0;
  localparam int T_OUT = 1;

  logic [FLAG_W-1:0] flags_q, flags_nxt, hw_set, hw_clr;
  logic [NDIR-1:0]   tog_q, tog_flip;
  logic              in_flight_q;
  hs_e               hs, hs_q;
  logic              setup_evt, out_accept, in_send, in_done, pid_sel;
  logic              tx_pid1_q, tx_zlp_q, irq_q, free_q;

  usb_ep_resp u_resp (
    .valid      (pkt_valid_i),
    .kind       (pkt_kind_i),
    .pid1       (pkt_pid1_i),
    .flags      (flags_q),
    .tog_in     (tog_q[T_IN]),
    .tog_out    (tog_q[T_OUT]),
    .in_flight  (in_flight_q),
    .hs         (hs),
    .setup_evt  (setup_evt),
    .out_accept (out_accept),
    .in_send    (in_send),
    .in_done    (in_done),
    .pid_sel    (pid_sel)
  );

  always_comb begin
    hw_set           = '0;
    hw_clr           = '0;
    hw_set[F_TXDONE] = in_done;
    hw_clr[F_TXRDY]  = in_done;
    hw_set[F_RXOUT]  = out_accept;
  end

  usb_ep_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .cpu_set   (cpu_set_i),
    .cpu_clr   (cpu_clr_i),
    .hw_set    (hw_set),
    .hw_clr    (hw_clr),
    .wipe      (setup_evt),
    .flags_q   (flags_q),
    .flags_nxt (flags_nxt)
  );

  assign tog_flip[T_IN]  = in_done;
  assign tog_flip[T_OUT] = out_accept;

  usb_ep_toggle #(.N(NDIR)) u_tog (
    .clk     (clk),
    .rst     (rst),
    .restart (setup_evt),
    .flip    (tog_flip),
    .tog_q   (tog_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q        <= HS_NONE;
      tx_pid1_q   <= 1'b0;
      tx_zlp_q    <= 1'b0;
      irq_q       <= 1'b0;
      free_q      <= 1'b1;
      in_flight_q <= 1'b0;
    end else begin
      hs_q   <= hs;
      irq_q  <= irq_en_i & |(flags_nxt & IRQ_MASK);
      free_q <= ~|(flags_nxt & HOLD_MASK);
      if (in_send) begin
        tx_pid1_q <= pid_sel;
        tx_zlp_q  <= (fifo_cnt_i == '0);
      end
      if (setup_evt)    in_flight_q <= 1'b0;
      else if (in_send) in_flight_q <= 1'b1;
      else if (in_done) in_flight_q <= 1'b0;
    end
  end

  assign status_o    = flags_q;
  assign hs_o        = hs_q;
  assign tx_pid1_o   = tx_pid1_q;
  assign tx_zlp_o    = tx_zlp_q;
  assign irq_o       = irq_q;
  assign fifo_free_o = free_q;

endmodule

// File: rtl/usb_ctl_ep_status_chk.sv
module usb_ctl_ep_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_en_i,
  input logic       pkt_valid_i,
  input logic [1:0] pkt_kind_i,
  input logic [5:0] status_o,
  input logic [2:0] hs_o,
  input logic       irq_o,
  input logic       fifo_free_o
);

  assert_setup_ack_R1: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_i && pkt_kind_i == 2'd0) |=> (hs_o == 3'd1 && status_o[4]));

  assert_setup_wipe_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[4]) |-> (status_o == 6'h10));

  assert_irq_masked_R3: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_i && pkt_kind_i == 2'd0 && !irq_en_i) |=> !irq_o);

  assert_fifo_held_R4: assert property (@(posedge clk) disable iff (rst)
    status_o[4] |-> !fifo_free_o);

  assert_in_nak_R5: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_i && pkt_kind_i == 2'd2 && !status_o[5] && !status_o[1]) |=> (hs_o == 3'd2));

  assert_out_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_i && pkt_kind_i == 2'd1 && !status_o[5] && (status_o[3] || status_o[4]))
      |=> (hs_o == 3'd2));

  assert_stall_R11: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_i && (pkt_kind_i == 2'd1 || pkt_kind_i == 2'd2) && status_o[5])
      |=> (hs_o == 3'd3));

endmodule

bind usb_ctl_ep_status usb_ctl_ep_status_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_en_i    (irq_en_i),
  .pkt_valid_i (pkt_valid_i),
  .pkt_kind_i  (pkt_kind_i),
  .status_o    (status_o),
  .hs_o        (hs_o),
  .irq_o       (irq_o),
  .fifo_free_o (fifo_free_o)
);

// File: tb/usb_ctl_ep_status_test.sv
`timescale 1ns/1ps
module usb_ctl_ep_status_test;

  localparam int CNT_W = 7;
  localparam int NV    = 39;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [5:0]       cpu_set = '0, cpu_clr = '0;
  logic             irq_en = 1'b0, pkt_valid = 1'b0, pkt_pid1 = 1'b0;
  logic [1:0]       pkt_kind = '0;
  logic [CNT_W-1:0] fifo_cnt = '0;
  logic [5:0]       status;
  logic [2:0]       hs;
  logic             tx_pid1, tx_zlp, irq, fifo_free;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  usb_ctl_ep_status #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cpu_set_i(cpu_set), .cpu_clr_i(cpu_clr),
    .irq_en_i(irq_en), .pkt_valid_i(pkt_valid), .pkt_kind_i(pkt_kind),
    .pkt_pid1_i(pkt_pid1), .fifo_cnt_i(fifo_cnt), .status_o(status),
    .hs_o(hs), .tx_pid1_o(tx_pid1), .tx_zlp_o(tx_zlp), .irq_o(irq),
    .fifo_free_o(fifo_free)
  );

  // {ien, set, clr, valid, kind, pid1, exp_hs, exp_status, exp_irq, exp_txpid}
  localparam logic [27:0] VEC [NV] = '{
    {1'b1,6'h00,6'h00,1'b1,2'd0,1'b0,3'd1,6'h10,1'b1,1'b0}, // SETUP R1 R9
    {1'b1,6'h01,6'h10,1'b0,2'd0,1'b0,3'd0,6'h01,1'b0,1'b0}, // dir=1, release R4
    {1'b1,6'h00,6'h00,1'b1,2'd2,1'b0,3'd2,6'h01,1'b0,1'b0}, // IN unarmed NAK R5
    {1'b1,6'h02,6'h00,1'b0,2'd0,1'b0,3'd0,6'h03,1'b0,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd2,1'b0,3'd4,6'h03,1'b0,1'b1}, // DATA1 R10
    {1'b1,6'h00,6'h00,1'b1,2'd3,1'b0,3'd0,6'h05,1'b1,1'b0}, // host ACK R6
    {1'b1,6'h02,6'h04,1'b0,2'd0,1'b0,3'd0,6'h03,1'b0,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd2,1'b0,3'd4,6'h03,1'b0,1'b0}, // DATA0 R10
    {1'b1,6'h00,6'h00,1'b1,2'd3,1'b0,3'd0,6'h05,1'b1,1'b0},
    {1'b1,6'h00,6'h05,1'b0,2'd0,1'b0,3'd0,6'h00,1'b0,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd1,1'b1,3'd1,6'h08,1'b1,1'b0}, // status OUT R7 R9
    {1'b1,6'h00,6'h00,1'b1,2'd1,1'b0,3'd2,6'h08,1'b1,1'b0}, // busy NAK R7
    {1'b1,6'h00,6'h08,1'b0,2'd0,1'b0,3'd0,6'h00,1'b0,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd0,1'b0,3'd1,6'h10,1'b1,1'b0}, // control write
    {1'b1,6'h00,6'h10,1'b0,2'd0,1'b0,3'd0,6'h00,1'b0,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd1,1'b1,3'd1,6'h08,1'b1,1'b0},
    {1'b1,6'h00,6'h08,1'b0,2'd0,1'b0,3'd0,6'h00,1'b0,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd1,1'b1,3'd1,6'h00,1'b0,1'b0}, // wrong toggle R8
    {1'b1,6'h00,6'h00,1'b1,2'd1,1'b0,3'd1,6'h08,1'b1,1'b0},
    {1'b1,6'h00,6'h08,1'b0,2'd0,1'b0,3'd0,6'h00,1'b0,1'b0},
    {1'b1,6'h02,6'h00,1'b0,2'd0,1'b0,3'd0,6'h02,1'b0,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd2,1'b0,3'd4,6'h02,1'b0,1'b1}, // status IN
    {1'b1,6'h00,6'h00,1'b1,2'd3,1'b0,3'd0,6'h04,1'b1,1'b0},
    {1'b1,6'h00,6'h04,1'b0,2'd0,1'b0,3'd0,6'h00,1'b0,1'b0},
    {1'b1,6'h20,6'h00,1'b0,2'd0,1'b0,3'd0,6'h20,1'b0,1'b0}, // stall R11
    {1'b1,6'h00,6'h00,1'b1,2'd2,1'b0,3'd3,6'h20,1'b0,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd1,1'b0,3'd3,6'h20,1'b0,1'b0},
    {1'b0,6'h00,6'h00,1'b1,2'd0,1'b0,3'd1,6'h10,1'b0,1'b0}, // masked irq R3
    {1'b0,6'h08,6'h00,1'b0,2'd0,1'b0,3'd0,6'h10,1'b0,1'b0}, // set ignored R12
    {1'b1,6'h00,6'h10,1'b0,2'd0,1'b0,3'd0,6'h00,1'b0,1'b0},
    {1'b1,6'h23,6'h00,1'b0,2'd0,1'b0,3'd0,6'h23,1'b0,1'b0},
    {1'b1,6'h01,6'h00,1'b1,2'd0,1'b0,3'd1,6'h10,1'b1,1'b0}, // wipe R2
    {1'b1,6'h03,6'h10,1'b0,2'd0,1'b0,3'd0,6'h03,1'b0,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd2,1'b0,3'd4,6'h03,1'b0,1'b1},
    {1'b1,6'h00,6'h00,1'b1,2'd3,1'b0,3'd0,6'h05,1'b1,1'b0},
    {1'b1,6'h02,6'h05,1'b0,2'd0,1'b0,3'd0,6'h02,1'b0,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd2,1'b0,3'd4,6'h02,1'b0,1'b1}, // forced DATA1 R10
    {1'b1,6'h00,6'h00,1'b1,2'd3,1'b0,3'd0,6'h04,1'b1,1'b0},
    {1'b1,6'h00,6'h00,1'b1,2'd3,1'b0,3'd0,6'h04,1'b1,1'b0}  // stray ACK R6
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic ien, input logic [5:0] s, input logic [5:0] c,
                      input logic v, input logic [1:0] k, input logic p,
                      input logic [CNT_W-1:0] cnt);
    @(negedge clk);
    irq_en = ien; cpu_set = s; cpu_clr = c; pkt_valid = v; pkt_kind = k;
    pkt_pid1 = p; fifo_cnt = cnt;
    @(posedge clk);
    #1;
    cpu_set = '0; cpu_clr = '0; pkt_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // reset state, R12 R4
    check("R12", "reset status", status, 0);
    check("R12", "reset hs", hs, 0);
    check("R3", "reset irq", irq, 0);
    check("R4", "reset fifo_free", fifo_free, 1);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] e;
      string req;
      e = VEC[i];
      step(e[27], e[26:21], e[20:15], e[14], e[13:12], e[11], '0);
      if (!e[14])              req = "R12";
      else if (e[13:12] == 0)  req = "R1";
      else if (e[13:12] == 1)  req = "R7";
      else if (e[13:12] == 2)  req = "R5";
      else                     req = "R6";
      check(req, $sformatf("vec%0d hs", i), hs, e[10:8]);
      check(req, $sformatf("vec%0d status", i), status, e[7:2]);
      check("R3", $sformatf("vec%0d irq", i), irq, e[1]);
      check("R4", $sformatf("vec%0d fifo_free", i), fifo_free,
            !(e[3] | e[5] | e[6]));
      if (e[10:8] == 3'd4) check("R10", $sformatf("vec%0d tx_pid1", i), tx_pid1, e[0]);
    end

    // zero-length detection on IN, R5
    step(1'b1, 6'h02, 6'h04, 1'b0, 2'd0, 1'b0, '0);
    step(1'b1, 6'h00, 6'h00, 1'b1, 2'd2, 1'b0, '0);
    check("R5", "zlp hs", hs, 4);
    check("R5", "zlp empty", tx_zlp, 1);
    step(1'b1, 6'h00, 6'h00, 1'b1, 2'd3, 1'b0, '0);
    step(1'b1, 6'h02, 6'h04, 1'b0, 2'd0, 1'b0, '0);
    step(1'b1, 6'h00, 6'h00, 1'b1, 2'd2, 1'b0, 7'd9);
    check("R5", "zlp nonempty", tx_zlp, 0);
    check("R4", "armed fifo_free", fifo_free, 0);

    // reset from a busy state
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R12", "re-reset status", status, 0);
    check("R12", "re-reset hs", hs, 0);
    check("R4", "re-reset fifo_free", fifo_free, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule